// File: doc/BRIEF.md
# Deferred Multiply Flag Evaluator

This block keeps a small record of the most recent flag-producing multiply and rebuilds the processor status flags only when a consumer asks for them. A producer writes an operation-kind code, the product word and an auxiliary word in one cycle. The flags are never stored. They are derived from the stored product, the overflow indicator held in the auxiliary word, and the operand-size tag carried by the kind code.

Two query ports read the record. A narrow port returns only the carry flag, for consumers such as conditional branches and carry-consuming arithmetic that need nothing else. A wide port returns the full packed flag word. One more kind code tells the block that the auxiliary word already holds a complete flag word. In that case the auxiliary word is passed through as it is.

Top module: `flag_eval_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the record is cleared to kind 0 with zero product and zero auxiliary word, even if `wr_en` is high. After reset, `flags_o` reads 0 and `carry_o` reads 0.
- R2: When `wr_en` is high at a rising edge and `rst` is low, kind, product and auxiliary word are captured. Both query ports reflect that write from the following cycle on and stay unchanged until the next write.
- R3: Kind code 0 (pass-through) makes `flags_o` equal to the low `FLAG_W` bits of the stored auxiliary word, and makes `carry_o` equal to bit 0 of that word.
- R4: For multiply kinds 1 (byte), 2 (word) and 3 (dword), flag bit 0 (carry) and flag bit 11 (overflow) are both 1 exactly when the stored auxiliary word is nonzero.
- R5: For multiply kinds, flag bit 2 (parity) is 1 when bits 7..0 of the product hold an even number of ones. The parity does not depend on operand size.
- R6: For multiply kinds, flag bit 6 (zero) is 1 when the product truncated to the operand size is all zeros. The operand size is 8 bits for kind 1, `DATA_W/2` bits for kind 2 and `DATA_W` bits for kind 3.
- R7: For multiply kinds, flag bit 7 (sign) equals the top bit of the product at the operand size: bit 7, bit `DATA_W/2-1` or bit `DATA_W-1`.
- R8: For multiply kinds, flag bit 4 (adjust) reads 0, and every bit other than 0, 2, 6, 7 and 11 reads 0.
- R9: `carry_o` uses the same nonzero-auxiliary rule for all three multiply sizes, and it always equals bit 0 of `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Capture a new record this cycle |
| wr_kind | input | 2 | Kind: 0 pass-through, 1 byte, 2 word, 3 dword multiply |
| wr_result | input | DATA_W | Multiply product (low word) |
| wr_aux | input | DATA_W | Overflow indicator, or a full flag word for kind 0 |
| carry_o | output | 1 | Carry-only query |
| flags_o | output | FLAG_W | Packed flag word query |

## Verification
The bench uses products whose zero and sign answers change with operand size. A value that is zero in its low byte but not at word width will expose a design that decodes the size wrongly: it would report the zero or sign of the wrong width. It also drives parity patterns in the low byte together with nonzero upper bytes, to catch parity taken over the wrong bits. It checks overflow that sits only in high auxiliary bits, to catch a carry rule that tests only bit 0. A pass-through write with scattered bits guards against a packer that masks or reorders the supplied word. Held cycles without writes, and writes issued during reset, check that the record changes only on a legal write.

// File: rtl/flag_eval_pkg.sv
package flag_eval_pkg;

    typedef enum logic [1:0] {
        KIND_PASS  = 2'd0,
        KIND_MUL8  = 2'd1,
        KIND_MUL16 = 2'd2,
        KIND_MUL32 = 2'd3
    } op_kind_e;

    localparam int CF_POS = 0;
    localparam int PF_POS = 2;
    localparam int AF_POS = 4;
    localparam int ZF_POS = 6;
    localparam int SF_POS = 7;
    localparam int OF_POS = 11;

    localparam int NUM_SIZES = 3;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic parity;
        logic carry;
    } mul_flags_t;

    function automatic logic even_parity8(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/flag_record_store.sv
module flag_record_store
    import flag_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  op_kind_e          wr_kind,
    input  logic [DATA_W-1:0] wr_result,
    input  logic [DATA_W-1:0] wr_aux,
    output op_kind_e          kind_q,
    output logic [DATA_W-1:0] result_q,
    output logic [DATA_W-1:0] aux_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= KIND_PASS;
            result_q <= '0;
            aux_q    <= '0;
        end else if (wr_en) begin
            kind_q   <= wr_kind;
            result_q <= wr_result;
            aux_q    <= wr_aux;
        end
    end

endmodule

// File: rtl/flag_size_view.sv
module flag_size_view
    import flag_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] result,
    output logic              zero,
    output logic              sign
);

    logic [NUM_SIZES-1:0] zero_v;
    logic [NUM_SIZES-1:0] sign_v;

    for (genvar i = 0; i < NUM_SIZES; i++) begin : g_size
        localparam int W_I = (i == 0) ? 8 : ((i == 1) ? DATA_W / 2 : DATA_W);
        assign zero_v[i] = (result[W_I-1:0] == '0);
        assign sign_v[i] = result[W_I-1];
    end

    always_comb begin
        unique case (kind)
            KIND_MUL8: begin
                zero = zero_v[0];
                sign = sign_v[0];
            end
            KIND_MUL16: begin
                zero = zero_v[1];
                sign = sign_v[1];
            end
            default: begin
                zero = zero_v[2];
                sign = sign_v[2];
            end
        endcase
    end

endmodule

// File: rtl/flag_word_pack.sv
module flag_word_pack
    import flag_eval_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 16
) (
    input  op_kind_e          kind,
    input  logic [7:0]        result_lo,
    input  logic [DATA_W-1:0] aux,
    input  logic              zero,
    input  logic              sign,
    output logic              carry,
    output logic [FLAG_W-1:0] flags
);

    mul_flags_t mf;

    always_comb begin
        mf.carry  = (aux != '0);
        mf.ovf    = mf.carry;
        mf.parity = even_parity8(result_lo);
        mf.zero   = zero;
        mf.sign   = sign;
    end

    always_comb begin
        flags = '0;
        carry = 1'b0;
        if (kind == KIND_PASS) begin
            flags = aux[FLAG_W-1:0];
            carry = aux[CF_POS];
        end else begin
            flags[CF_POS] = mf.carry;
            flags[PF_POS] = mf.parity;
            flags[AF_POS] = 1'b0;
            flags[ZF_POS] = mf.zero;
            flags[SF_POS] = mf.sign;
            flags[OF_POS] = mf.ovf;
            carry         = mf.carry;
        end
    end

endmodule

// File: rtl/flag_eval_unit.sv
module flag_eval_unit
    import flag_eval_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [DATA_W-1:0] wr_result,
    input  logic [DATA_W-1:0] wr_aux,
    output logic              carry_o,
    output logic [FLAG_W-1:0] flags_o
);

    op_kind_e          kind_q;
    logic [DATA_W-1:0] result_q;
    logic [DATA_W-1:0] aux_q;
    logic              zero_w;
    logic              sign_w;

    flag_record_store #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_kind   (op_kind_e'(wr_kind)),
        .wr_result (wr_result),
        .wr_aux    (wr_aux),
        .kind_q    (kind_q),
        .result_q  (result_q),
        .aux_q     (aux_q)
    );

    flag_size_view #(.DATA_W(DATA_W)) u_size (
        .kind   (kind_q),
        .result (result_q),
        .zero   (zero_w),
        .sign   (sign_w)
    );

    flag_word_pack #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_pack (
        .kind      (kind_q),
        .result_lo (result_q[7:0]),
        .aux       (aux_q),
        .zero      (zero_w),
        .sign      (sign_w),
        .carry     (carry_o),
        .flags     (flags_o)
    );

endmodule

// File: rtl/flag_eval_chk.sv
module flag_eval_chk #(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_kind,
    input logic [DATA_W-1:0] wr_result,
    input logic [DATA_W-1:0] wr_aux,
    input logic              carry_o,
    input logic [FLAG_W-1:0] flags_o
);

    localparam logic [FLAG_W-1:0] MUL_MASK = FLAG_W'(16'h08C5);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags_o == '0 && carry_o == 1'b0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(flags_o) && $stable(carry_o)));

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == 2'd0) |=> (flags_o == $past(wr_aux[FLAG_W-1:0])));

    // R4
    carry_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind != 2'd0) |=> (flags_o[11] == ($past(wr_aux) != '0)));

    // R5
    parity_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind != 2'd0) |=> (flags_o[2] == ~(^$past(wr_result[7:0]))));

    // R6
    zero_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == 2'd1) |=> (flags_o[6] == ($past(wr_result[7:0]) == 8'h00)));

    // R7
    sign_dword_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == 2'd3) |=> (flags_o[7] == $past(wr_result[DATA_W-1])));

    // R8
    undefined_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind != 2'd0) |=> ((flags_o & ~MUL_MASK) == '0));

    // R9
    carry_port_chk: assert property (@(posedge clk) disable iff (rst)
        carry_o == flags_o[0]);

endmodule

bind flag_eval_unit flag_eval_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_kind   (wr_kind),
    .wr_result (wr_result),
    .wr_aux    (wr_aux),
    .carry_o   (carry_o),
    .flags_o   (flags_o)
);

// File: tb/sim_flag_eval_unit.sv
module sim_flag_eval_unit;

    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;
    localparam int FLAG_W = 16;
    localparam int WATCHDOG = 5000;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [1:0]        wr_kind;
    logic [DATA_W-1:0] wr_result;
    logic [DATA_W-1:0] wr_aux;
    logic              carry_o;
    logic [FLAG_W-1:0] flags_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    flag_eval_unit #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_result(wr_result), .wr_aux(wr_aux),
        .carry_o(carry_o), .flags_o(flags_o)
    );

    task automatic chk(input string tag, input logic [FLAG_W-1:0] got, input logic [FLAG_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic write_rec(input logic [1:0] k, input logic [DATA_W-1:0] res, input logic [DATA_W-1:0] aux);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_result = res; wr_aux = aux;
        @(negedge clk);
        wr_en = 1'b0; wr_kind = 2'd0; wr_result = '1; wr_aux = '1;
    endtask

    // Multiply write followed by per-flag checks derived from the requirements
    task automatic mul_case(input logic [1:0] k, input logic [DATA_W-1:0] res, input logic [DATA_W-1:0] aux);
        int w;
        logic ec, ep, ez, es;
        write_rec(k, res, aux);
        w  = (k == 2'd1) ? 8 : ((k == 2'd2) ? DATA_W/2 : DATA_W);
        ec = (aux != '0);
        ep = ~(^res[7:0]);
        ez = ((res & ((w == DATA_W) ? {DATA_W{1'b1}} : ((DATA_W'(1) << w) - 1))) == '0);
        es = res[w-1];
        chk("R4 carry bit", FLAG_W'(flags_o[0]), FLAG_W'(ec));
        chk("R4 overflow bit", FLAG_W'(flags_o[11]), FLAG_W'(ec));
        chk("R5 parity bit", FLAG_W'(flags_o[2]), FLAG_W'(ep));
        chk("R6 zero bit", FLAG_W'(flags_o[6]), FLAG_W'(ez));
        chk("R7 sign bit", FLAG_W'(flags_o[7]), FLAG_W'(es));
        chk("R8 adjust and undefined bits", flags_o & ~FLAG_W'(16'h08C5), '0);
        chk("R9 carry port", FLAG_W'(carry_o), FLAG_W'(ec));
    endtask

    task automatic test_reset();
        rst = 1'b1;
        wr_en = 1'b1; wr_kind = 2'd3; wr_result = 32'h8000_0000; wr_aux = 32'h1;
        repeat (3) @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        chk("R1 flags after reset", flags_o, '0);
        chk("R1 carry after reset", FLAG_W'(carry_o), '0);
    endtask

    task automatic test_pass();
        write_rec(2'd0, 32'h0000_0000, 32'hABCD_08D5);
        chk("R3 pass-through word", flags_o, 16'h08D5);
        chk("R3 pass-through carry", FLAG_W'(carry_o), 16'h1);
        write_rec(2'd0, 32'hFFFF_FFFF, 32'h0000_0FFE);
        chk("R3 pass-through carry clear", FLAG_W'(carry_o), 16'h0);
        chk("R3 pass-through word 2", flags_o, 16'h0FFE);
    endtask

    task automatic test_sizes();
        mul_case(2'd1, 32'h0000_1200, 32'h0000_0012); // R6 byte zero with high bits set
        chk("R2 byte zero word", flags_o, 16'h0845);
        mul_case(2'd1, 32'h0000_0080, 32'h0);         // R7 byte sign
        chk("R2 byte sign word", flags_o, 16'h0080);
        mul_case(2'd2, 32'h0001_0000, 32'h0);         // R6 word zero, dword not zero
        chk("R2 word zero word", flags_o, 16'h0044);
        mul_case(2'd2, 32'h0000_8003, 32'h0000_0001);
        chk("R2 word sign word", flags_o, 16'h0885);
        mul_case(2'd3, 32'h8000_0000, 32'h0);         // R7 dword sign, byte would be zero
        chk("R2 dword sign word", flags_o, 16'h0084);
        mul_case(2'd3, 32'h0000_0000, 32'hFFFF_FFFF);
        chk("R2 dword zero word", flags_o, 16'h0845);
        mul_case(2'd3, 32'h1234_5601, 32'h8000_0000); // R4 overflow only in top aux bit
        chk("R9 carry high aux bit", FLAG_W'(carry_o), 16'h1);
        mul_case(2'd1, 32'hFFFF_FF07, 32'h0);         // R5 odd parity low byte
    endtask

    task automatic test_hold();
        logic [FLAG_W-1:0] snap;
        mul_case(2'd2, 32'h0000_C0C0, 32'h0000_0100);
        snap = flags_o;
        wr_kind = 2'd0; wr_result = '0; wr_aux = '0;
        repeat (4) @(negedge clk);
        chk("R2 hold without write", flags_o, snap);
        chk("R2 hold carry", FLAG_W'(carry_o), 16'h1);
        write_rec(2'd1, 32'h0000_0001, 32'h0);
        chk("R2 latest write wins", flags_o, 16'h0000);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_kind = '0; wr_result = '0; wr_aux = '0;
        test_reset();
        test_pass();
        test_sizes();
        test_hold();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule